// File: doc/BRIEF.md
# Sixteen-bit Conditional-Execute Processor Core

A small non-pipelined processor core running an eight-instruction set of fixed 16-bit instructions. Code and data live in one word-addressed memory reached through a single synchronous port (address, write data, write enable, read data with one cycle of latency). Because loads and stores use that same memory, a program can read its own instruction words and overwrite instructions that have not yet executed.

Every instruction passes through five named states of a sequencer: FETCH (program counter on the address bus), DECODE (instruction word captured), EXEC (operands read, result and flags computed, condition evaluated), MEM (load or store address on the bus, write strobe for a store) and WB (register and flag update, program counter step). The transitions are FETCH to DECODE, DECODE to EXEC, EXEC to MEM, MEM to WB and WB back to FETCH, with no other path. Reset places the sequencer in FETCH. The register file has eight 16-bit entries; entry 0 is a constant zero. A four-bit flag register holds carry, overflow, negative and zero. A debug view brings out every register and the flags.

Top module: `cpu16_core`

## Requirements
- R1: While reset is active and right after its release, all eight registers and the flags read 0, the address bus shows 0 and the write strobe is low.
- R2: Each instruction takes exactly five clocks; the address bus shows the program counter in the FETCH state, the counter starts at 0 and grows by one per instruction whether or not the instruction takes effect.
- R3: Opcode in bits 15..12, destination index in bits 10..8, immediate in bits 7..0: opcode 0000 writes the zero-extended immediate to the destination; opcode 0010 writes the immediate into the high byte and keeps the destination's low byte.
- R4: Register-form fields are source A in bits 6..4 and source B in bits 2..0 (bits 7 and 3 zero); opcode 1000 writes A AND B, opcode 1001 writes A OR B; both set Z and N from the result and clear C and V.
- R5: Opcode 1010 writes A + B; C is the carry out of bit 15, V is set when both inputs share a sign that the result lacks, N is bit 15 of the result and Z marks a zero result.
- R6: Opcode 1011 writes A - B computed as A + ~B + 1; C is the carry out of that sum, V is set when the inputs differ in sign and the result has the sign of B, N and Z as for addition.
- R7: Opcode 0100 loads into the destination the memory word at the address held in source A; opcode 0111 writes the destination register to that address, and a store to a not-yet-fetched address changes the instruction executed there.
- R8: Register 0 always reads as 0 and writes to it are dropped, while an arithmetic or logic instruction aimed at it still updates the flags.
- R9: Bit 11 is a condition bit: when 1, the instruction takes effect only if Z is set and otherwise changes no register, flag or memory word; when 0, it always takes effect.
- R10: Any opcode outside the eight listed changes no register, flag or memory word.
- R11: Opcodes 0000, 0010, 0100 and 0111 leave the flags unchanged. The debug flag output packs C, V, N, Z in bits 3, 2, 1, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Word address for fetch, load or store |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Store strobe, one clock in the MEM state |
| mem_rdata | input | 16 | Read data, valid the clock after the address |
| dbg_regs | output | 128 | Register file, entry i at bits 16*i+15..16*i |
| dbg_flags | output | 4 | Flags C, V, N, Z in bits 3..0 |

## Verification
A wrong sequencer state shows on the address bus at the next fetch: the program counter sampled every five clocks must walk 0, 1, 2 without gaps, so a lost or repeated state is visible within one instruction. A wrong operand, result or flag lands in the debug view at the WB edge of the instruction that produced it, so the bench compares registers and flags after every short program that sweeps a grid of sign, carry and overflow corner operands across all four arithmetic and logic operations. A wrong condition or decode decision shows as a register, flag or memory word that changed when it should have been left alone, checked right after the instruction.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned REG_CNT = 8;
    localparam int unsigned FLAG_W  = 4;

    // flag bit positions in the CVNZ vector
    localparam int FLG_Z = 0;
    localparam int FLG_N = 1;
    localparam int FLG_V = 2;
    localparam int FLG_C = 3;

    typedef enum logic [3:0] {
        OP_MOVL = 4'b0000,
        OP_SETH = 4'b0010,
        OP_LDR  = 4'b0100,
        OP_STR  = 4'b0111,
        OP_AND  = 4'b1000,
        OP_ORR  = 4'b1001,
        OP_ADD  = 4'b1010,
        OP_SUB  = 4'b1011
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_WB
    } phase_e;

    // low two opcode bits select the arithmetic/logic function
    localparam logic [1:0] FN_AND = 2'b00;
    localparam logic [1:0] FN_ORR = 2'b01;
    localparam logic [1:0] FN_ADD = 2'b10;
    localparam logic [1:0] FN_SUB = 2'b11;

    typedef struct packed {
        logic imm_low;   // zero-extended immediate write
        logic imm_high;  // high-byte immediate write
        logic mem_rd;    // load
        logic mem_wr;    // store
        logic alu;       // arithmetic / logic, updates flags
    } op_class_t;

endpackage

// File: rtl/cpu16_seq.sv
module cpu16_seq
    import cpu16_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase,
    output logic   in_fetch,
    output logic   in_decode,
    output logic   in_exec,
    output logic   in_mem,
    output logic   in_wb
);

    phase_e state_q;
    phase_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: a fixed five-step ring
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC:   state_d = ST_MEM;
            ST_MEM:    state_d = ST_WB;
            ST_WB:     state_d = ST_FETCH;
            default:   state_d = ST_FETCH;
        endcase
    end

    // per-state strobes
    always_comb begin
        in_fetch  = 1'b0;
        in_decode = 1'b0;
        in_exec   = 1'b0;
        in_mem    = 1'b0;
        in_wb     = 1'b0;
        unique case (state_q)
            ST_FETCH:  in_fetch  = 1'b1;
            ST_DECODE: in_decode = 1'b1;
            ST_EXEC:   in_exec   = 1'b1;
            ST_MEM:    in_mem    = 1'b1;
            ST_WB:     in_wb     = 1'b1;
            default:   in_fetch  = 1'b0;
        endcase
    end

    assign phase = state_q;

    // R2: the ring never skips a step
    p_ring_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WB) |=> (state_q == ST_FETCH));
    p_fetch_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

endmodule

// File: rtl/cpu16_decode.sv
module cpu16_decode
    import cpu16_pkg::*;
#(
    parameter int unsigned DW   = WORD_W,
    parameter int unsigned NREG = REG_CNT,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic [DW-1:0] instr,
    output op_class_t     cls,
    output logic          cond,
    output logic [IW-1:0] rd,
    output logic [IW-1:0] ra,
    output logic [IW-1:0] rb,
    output logic [7:0]    imm,
    output logic [1:0]    alu_fn
);

    logic [3:0] opc;

    assign opc    = instr[15:12];
    assign cond   = instr[11];
    assign rd     = instr[8 +: IW];
    assign ra     = instr[4 +: IW];
    assign rb     = instr[0 +: IW];
    assign imm    = instr[7:0];
    assign alu_fn = instr[13:12];

    always_comb begin
        cls = '0;
        case (opc)
            OP_MOVL: cls.imm_low  = 1'b1;
            OP_SETH: cls.imm_high = 1'b1;
            OP_LDR:  cls.mem_rd   = 1'b1;
            OP_STR:  cls.mem_wr   = 1'b1;
            OP_AND,
            OP_ORR,
            OP_ADD,
            OP_SUB:  cls.alu      = 1'b1;
            default: cls          = '0;  // R10: unknown opcode does nothing
        endcase
    end

    // R10: at most one class is ever selected
    always_comb begin
        a_one_class_r10: assert ($onehot0(cls));
    end

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  logic [1:0]        fn,
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    output logic [DW-1:0]     res,
    output logic [FLAG_W-1:0] cvnz
);

    logic [DW-1:0] b_eff;
    logic [DW:0]   sum;
    logic          carry;
    logic          ovf;

    always_comb begin
        b_eff = (fn == FN_SUB) ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, (fn == FN_SUB)};
        carry = 1'b0;
        ovf   = 1'b0;
        unique case (fn)
            FN_AND: res = a & b;
            FN_ORR: res = a | b;
            FN_ADD,
            FN_SUB: begin
                res   = sum[DW-1:0];
                carry = sum[DW];
                ovf   = (a[DW-1] == b_eff[DW-1]) && (res[DW-1] != a[DW-1]);
            end
            default: res = '0;
        endcase
        cvnz[FLG_C] = carry;
        cvnz[FLG_V] = ovf;
        cvnz[FLG_N] = res[DW-1];
        cvnz[FLG_Z] = (res == '0);
    end

    // R4: logic operations never report carry or overflow
    always_comb begin
        if (fn == FN_AND || fn == FN_ORR) begin
            a_logic_cv_r4: assert (cvnz[FLG_C] == 1'b0 && cvnz[FLG_V] == 1'b0);
        end
    end

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
    import cpu16_pkg::*;
#(
    parameter int unsigned DW   = WORD_W,
    parameter int unsigned NREG = REG_CNT,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    a_idx,
    output logic [DW-1:0]    a_val,
    input  logic [IW-1:0]    b_idx,
    output logic [DW-1:0]    b_val,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_val,
    output logic [NREG*DW-1:0] view
);

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_en && (wr_idx != '0)) begin
            // R8: index 0 is never written
            regs[wr_idx] <= wr_val;
        end
    end

    assign a_val = regs[a_idx];
    assign b_val = regs[b_idx];

    for (genvar g = 0; g < NREG; g++) begin : g_view
        assign view[g*DW +: DW] = regs[g];
    end

    // R8: the zero entry stays zero across every write
    p_zero_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0] == '0);

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
#(
    parameter int unsigned DW   = WORD_W,
    parameter int unsigned NREG = REG_CNT,
    localparam int unsigned IW  = $clog2(NREG),
    localparam int unsigned LOW = DW - 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [DW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    output logic               mem_we,
    input  logic [DW-1:0]      mem_rdata,
    output logic [NREG*DW-1:0] dbg_regs,
    output logic [FLAG_W-1:0]  dbg_flags
);

    phase_e phase;
    logic   in_fetch, in_decode, in_exec, in_mem, in_wb;

    logic [DW-1:0]     pc;
    logic [DW-1:0]     ir;
    logic [DW-1:0]     res_q;
    logic [DW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic [FLAG_W-1:0] flags;
    logic [FLAG_W-1:0] flg_q;
    logic              take_q;

    op_class_t     cls;
    logic          cond;
    logic [IW-1:0] rd, ra, rb;
    logic [7:0]    imm;
    logic [1:0]    alu_fn;

    logic [DW-1:0]     a_val, b_val, alu_res, res_d;
    logic [FLAG_W-1:0] alu_flags;
    logic [IW-1:0]     b_idx;
    logic              take;
    logic              rf_we;
    logic [DW-1:0]     rf_wdata;

    cpu16_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .in_fetch  (in_fetch),
        .in_decode (in_decode),
        .in_exec   (in_exec),
        .in_mem    (in_mem),
        .in_wb     (in_wb)
    );

    cpu16_decode #(.DW(DW), .NREG(NREG)) u_dec (
        .instr  (ir),
        .cls    (cls),
        .cond   (cond),
        .rd     (rd),
        .ra     (ra),
        .rb     (rb),
        .imm    (imm),
        .alu_fn (alu_fn)
    );

    // port B reads rb for arithmetic, rd for high-byte merge and store data
    assign b_idx = cls.alu ? rb : rd;

    cpu16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_idx  (ra),
        .a_val  (a_val),
        .b_idx  (b_idx),
        .b_val  (b_val),
        .wr_en  (rf_we),
        .wr_idx (rd),
        .wr_val (rf_wdata),
        .view   (dbg_regs)
    );

    cpu16_alu #(.DW(DW)) u_alu (
        .fn   (alu_fn),
        .a    (a_val),
        .b    (b_val),
        .res  (alu_res),
        .cvnz (alu_flags)
    );

    // R9: condition bit gates on the zero flag
    assign take = !cond || flags[FLG_Z];

    always_comb begin
        res_d = alu_res;
        if (cls.imm_low) begin
            res_d = {{LOW{1'b0}}, imm};
        end else if (cls.imm_high) begin
            res_d = {imm, b_val[LOW-1:0]};
        end
    end

    // datapath registers, each loaded in its own state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc      <= '0;
            ir      <= '0;
            res_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            flags   <= '0;
            flg_q   <= '0;
            take_q  <= 1'b0;
        end else begin
            if (in_decode) begin
                ir <= mem_rdata;
            end
            if (in_exec) begin
                res_q   <= res_d;
                flg_q   <= alu_flags;
                addr_q  <= a_val;
                wdata_q <= b_val;
                take_q  <= take;
            end
            if (in_wb) begin
                pc <= pc + 1'b1;
                if (take_q && cls.alu) begin
                    flags <= flg_q;
                end
            end
        end
    end

    assign rf_we    = in_wb && take_q &&
                      (cls.imm_low || cls.imm_high || cls.mem_rd || cls.alu);
    assign rf_wdata = cls.mem_rd ? mem_rdata : res_q;

    assign mem_addr  = in_mem ? addr_q : pc;
    assign mem_wdata = wdata_q;
    assign mem_we    = in_mem && take_q && cls.mem_wr;
    assign dbg_flags = flags;

    // R2: fetch address is the program counter, never with a write
    p_fetch_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_fetch |-> (mem_addr == pc && !mem_we));
    // R2: counter steps by one after each writeback
    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_wb |=> (pc == $past(pc) + 1'b1));
    // R11: flags move only at writeback
    p_flags_only_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_wb |=> $stable(flags));
    // R7: a store strobe lasts one clock
    p_store_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    // R9: a skipped instruction leaves the register file alone
    p_skip_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wb && !take_q) |=> $stable(dbg_regs));

endmodule

// File: tb/cpu16_core_test.sv
module cpu16_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] mem_addr, mem_wdata, mem_rdata;
    logic          mem_we;
    logic [8*DW-1:0] dbg_regs;
    logic [3:0]    dbg_flags;

    logic [DW-1:0] mem [0:255];
    logic          pl_we = 1'b0;
    logic [7:0]    pl_addr = '0;
    logic [DW-1:0] pl_data = '0;
    logic [DW-1:0] prog [0:15];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu16_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .dbg_regs  (dbg_regs),
        .dbg_flags (dbg_flags)
    );

    // synchronous memory model with preload path
    always @(posedge clk) begin
        if (pl_we) begin
            mem[pl_addr] <= pl_data;
        end else if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr[7:0]];
    end

    localparam logic [3:0] O_MOVL = 4'b0000, O_SETH = 4'b0010, O_LDR = 4'b0100,
                           O_STR = 4'b0111, O_AND = 4'b1000, O_ORR = 4'b1001,
                           O_ADD = 4'b1010, O_SUB = 4'b1011;

    function automatic logic [15:0] enc_i(logic [3:0] op, logic c, int d, logic [7:0] v);
        return {op, c, 3'(d), v};
    endfunction

    function automatic logic [15:0] enc_r(logic [3:0] op, logic c, int d, int a, int b);
        return {op, c, 3'(d), 1'b0, 3'(a), 1'b0, 3'(b)};
    endfunction

    function automatic logic [15:0] reg_of(int i);
        return dbg_regs[i*DW +: DW];
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) prog[i] = 16'h0000;
    endtask

    // hold reset, preload 16 words, release, run n instructions
    task automatic run(int n);
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            pl_we = 1'b1; pl_addr = 8'(i); pl_data = prog[i];
        end
        @(negedge clk);
        pl_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < n; k++) begin
            check("R2 fetch address", mem_addr, 16'(k));
            repeat (5) @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic void model(logic [1:0] fn, logic [15:0] a, logic [15:0] b,
                                  output logic [15:0] r, output logic [3:0] f);
        logic [16:0] s;
        logic c, v;
        c = 1'b0; v = 1'b0;
        case (fn)
            2'b00: r = a & b;
            2'b01: r = a | b;
            2'b10: begin
                s = {1'b0, a} + {1'b0, b};
                r = s[15:0]; c = s[16];
                v = (a[15] == b[15]) && (r[15] != a[15]);
            end
            default: begin
                s = {1'b0, a} + {1'b0, ~b} + 17'd1;
                r = s[15:0]; c = s[16];
                v = (a[15] != b[15]) && (r[15] == b[15]);
            end
        endcase
        f = {c, v, r[15], (r == 16'h0)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] vals [13];
        logic [15:0] er;
        logic [3:0]  ef;
        string       tag;
        vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'h8001,
                 16'hFFFF, 16'hFFFE, 16'h00FF, 16'hFF00, 16'h5555, 16'hAAAA, 16'h1234};

        // R1: reset state
        clear_prog();
        for (int i = 0; i < 16; i++) mem[i] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 8; i++) check("R1 register", reg_of(i), 16'h0);
        check("R1 flags", {12'h0, dbg_flags}, 16'h0);
        check("R1 address", mem_addr, 16'h0);
        check("R1 write strobe", {15'h0, mem_we}, 16'h0);

        // R3 / R11 / R7: immediates, load of own code, store, flags kept
        clear_prog();
        prog[0] = enc_i(O_MOVL, 0, 1, 8'h01);
        prog[1] = enc_r(O_SUB, 0, 3, 1, 1);
        prog[2] = enc_i(O_MOVL, 0, 4, 8'h55);
        prog[3] = enc_i(O_SETH, 0, 4, 8'h80);
        prog[4] = enc_r(O_LDR, 0, 5, 0, 0);
        prog[5] = enc_r(O_STR, 0, 4, 1, 0);
        run(6);
        check("R11 flags kept", {12'h0, dbg_flags}, 16'h0009);
        check("R3 high byte merge", reg_of(4), 16'h8055);
        check("R7 load own code", reg_of(5), 16'h0101);
        check("R7 store word", mem[1], 16'h8055);

        // R3: zero-extension clears an old high byte
        clear_prog();
        prog[0] = enc_i(O_MOVL, 0, 1, 8'h34);
        prog[1] = enc_i(O_SETH, 0, 1, 8'h12);
        prog[2] = enc_i(O_MOVL, 0, 2, 8'hAB);
        prog[3] = enc_i(O_SETH, 0, 2, 8'hCD);
        prog[4] = enc_i(O_MOVL, 0, 2, 8'hEF);
        run(5);
        check("R3 seth", reg_of(1), 16'h1234);
        check("R3 movl zero-extend", reg_of(2), 16'h00EF);

        // R7: store rewrites the next instruction before it is fetched
        clear_prog();
        prog[0] = enc_i(O_MOVL, 0, 1, 8'h04);
        prog[1] = enc_i(O_MOVL, 0, 2, 8'h77);
        prog[2] = enc_i(O_SETH, 0, 2, 8'h03);
        prog[3] = enc_r(O_STR, 0, 2, 1, 0);
        prog[4] = enc_i(O_MOVL, 0, 3, 8'h11);
        prog[5] = enc_r(O_LDR, 0, 5, 1, 0);
        run(6);
        check("R7 modified code executed", reg_of(3), 16'h0077);
        check("R7 load modified word", reg_of(5), 16'h0377);

        // R8: zero register
        clear_prog();
        prog[0] = enc_i(O_MOVL, 0, 1, 8'h01);
        prog[1] = enc_i(O_MOVL, 0, 0, 8'h55);
        prog[2] = enc_r(O_SUB, 0, 0, 1, 1);
        prog[3] = enc_r(O_ADD, 0, 3, 0, 1);
        run(3);
        check("R8 write dropped", reg_of(0), 16'h0);
        check("R8 flags still set", {12'h0, dbg_flags}, 16'h0009);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R8 reads zero", reg_of(3), 16'h0001);

        // R9: condition false (Z clear) skips writes and flags
        clear_prog();
        prog[0] = enc_i(O_MOVL, 1, 1, 8'h05);
        prog[1] = enc_i(O_MOVL, 0, 2, 8'h09);
        prog[2] = enc_r(O_SUB, 1, 6, 2, 0);
        prog[3] = enc_r(O_STR, 1, 2, 2, 0);
        run(4);
        check("R9 skipped movl", reg_of(1), 16'h0);
        check("R9 unconditional", reg_of(2), 16'h0009);
        check("R9 skipped sub reg", reg_of(6), 16'h0);
        check("R9 skipped sub flags", {12'h0, dbg_flags}, 16'h0);
        check("R9 skipped store", mem[9], 16'h0);

        // R9: condition true (Z set) executes, then Z clears and skips
        clear_prog();
        prog[0] = enc_r(O_SUB, 0, 2, 0, 0);
        prog[1] = enc_i(O_MOVL, 1, 3, 8'h07);
        prog[2] = enc_r(O_ADD, 1, 4, 3, 3);
        prog[3] = enc_r(O_ORR, 1, 5, 3, 3);
        run(4);
        check("R9 taken movl", reg_of(3), 16'h0007);
        check("R9 taken add", reg_of(4), 16'h000E);
        check("R9 skipped orr", reg_of(5), 16'h0);
        check("R9 flags after add", {12'h0, dbg_flags}, 16'h0);

        // R10: undefined opcodes
        clear_prog();
        prog[0] = enc_i(O_MOVL, 0, 1, 8'h03);
        prog[1] = 16'h1123;
        prog[2] = 16'h5123;
        prog[3] = 16'h6110;
        prog[4] = 16'hC1FF;
        prog[5] = 16'hF111;
        run(6);
        check("R10 register kept", reg_of(1), 16'h0003);
        check("R10 flags kept", {12'h0, dbg_flags}, 16'h0);
        check("R10 memory kept", mem[3], 16'h6110);
        for (int i = 2; i < 8; i++) check("R10 other registers", reg_of(i), 16'h0);

        // R4 / R5 / R6: operand grid across all four operations
        for (int fn = 0; fn < 4; fn++) begin
            tag = (fn < 2) ? "R4" : ((fn == 2) ? "R5" : "R6");
            for (int i = 0; i < 13; i++) begin
                for (int j = 0; j < 13; j++) begin
                    clear_prog();
                    prog[0] = enc_i(O_MOVL, 0, 1, vals[i][7:0]);
                    prog[1] = enc_i(O_SETH, 0, 1, vals[i][15:8]);
                    prog[2] = enc_i(O_MOVL, 0, 2, vals[j][7:0]);
                    prog[3] = enc_i(O_SETH, 0, 2, vals[j][15:8]);
                    prog[4] = enc_r({2'b10, 2'(fn)}, 0, 3, 1, 2);
                    run(5);
                    model(2'(fn), vals[i], vals[j], er, ef);
                    check({tag, " result"}, reg_of(3), er);
                    check({tag, " flags"}, {12'h0, dbg_flags}, {12'h0, ef});
                end
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule